// File: doc/BRIEF.md
# Burst DMA Handshake Controller

This block runs on the 100 MHz clock of a USB bridge's parallel port and moves fixed-length bursts of samples between that port and two dual-clock sample FIFOs. The FIFOs carry samples to and from the converter's sample clock domain. In the receive direction it drains the RX FIFO onto the bridge bus. In the transmit direction it fills the TX FIFO from words the bridge presents.

A burst starts only when three things agree for one direction: the FIFO can supply (RX) or absorb (TX) a whole burst, the host has enabled that direction, and the bridge is requesting a DMA transfer for it. The burst length depends on the bus speed: 512 samples in superspeed and 256 in high speed. The speed is taken when the burst starts. Once started, a burst always runs to its full length. Each burst is followed by one turnaround cycle. When both directions are ready at the same time, the controller alternates between them.

Top module: `burst_dma_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `rx_fifo_rd`, `tx_fifo_wr`, `bus_dout_valid` and `bus_dir` are all low. After reset the controller is idle.
- R2: An RX burst begins (`rx_fifo_rd` rises in the next cycle) only from idle, and only when `rx_en`, `rx_dma_req` and `rx_fifo_level >= burst length` all hold in the same cycle.
- R3: A TX burst begins (`bus_dir` rises in the next cycle) only from idle, and only when `tx_en`, `tx_dma_req` and `tx_fifo_free >= burst length` all hold in the same cycle.
- R4: The burst length is 512 when `mode_ss` = 1 and 256 when `mode_ss` = 0. The value is taken in the cycle the burst is granted. Changes of `mode_ss` during a burst have no effect on that burst.
- R5: An RX burst holds `rx_fifo_rd` high for exactly the burst length in consecutive cycles. Dropping `rx_en`, `rx_dma_req` or the level during the burst does not shorten it.
- R6: The RX FIFO is first-word-fall-through. The cycle after each cycle with `rx_fifo_rd` high, `bus_dout_valid` is high and `bus_dout` equals the `rx_fifo_data` present during the read. Otherwise `bus_dout_valid` is low.
- R7: During a TX burst `bus_dir` = 1. Each cycle with `bus_din_valid` high is one accepted word. The next cycle, `tx_fifo_wr` pulses with `tx_fifo_data` equal to that word. The burst ends after exactly burst-length accepted words, and cycles without valid data do not count.
- R8: After each burst there are exactly two cycles (turnaround, then idle) with both `rx_fifo_rd` and `bus_dir` low before the next burst can begin.
- R9: When both directions are eligible in idle, grants alternate between RX and TX. After reset, RX has first priority.
- R10: `rx_fifo_rd` and `bus_dir` are never high together, and `tx_fifo_wr` never pulses in a cycle with `rx_fifo_rd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge interface clock (100 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| mode_ss | input | 1 | 1 = superspeed (512-sample bursts), 0 = high speed (256) |
| rx_en | input | 1 | Host has enabled the receive direction |
| rx_dma_req | input | 1 | Bridge requests a receive DMA transfer |
| rx_fifo_level | input | LVL_W | Words held in the RX FIFO |
| rx_fifo_data | input | DATA_W | RX FIFO head word (first-word-fall-through) |
| rx_fifo_rd | output | 1 | RX FIFO read strobe |
| tx_en | input | 1 | Host has enabled the transmit direction |
| tx_dma_req | input | 1 | Bridge requests a transmit DMA transfer |
| tx_fifo_free | input | LVL_W | Free word slots in the TX FIFO |
| tx_fifo_wr | output | 1 | TX FIFO write strobe |
| tx_fifo_data | output | DATA_W | Word written to the TX FIFO |
| bus_din | input | DATA_W | Word from the bridge |
| bus_din_valid | input | 1 | `bus_din` holds a valid word |
| bus_dout | output | DATA_W | Word to the bridge |
| bus_dout_valid | output | 1 | `bus_dout` holds a valid word |
| bus_dir | output | 1 | 1 while a TX burst is in progress (bridge drives data) |

## Verification
The assertions check every cycle that the directions never overlap (R10), that read strobes and output valids stay in lockstep (R6), and that write pulses follow valid bridge words (R7). They also check that each burst start was preceded by a cycle in which all three start conditions held (R2, R3), that each RX run has the length chosen at its start (R4, R5), and that a turnaround follows every RX burst (R8). Only the bench scenarios can show the rest. These are that a level one short of a burst or a missing enable really holds a burst back, that the data values come through in order, that a speed change or a withdrawn request in mid-burst is ignored, and that under contention the grants alternate starting with RX.

// File: rtl/burst_dma_pkg.sv
package burst_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_TX   = 2'd2,
    ST_TURN = 2'd3
  } dma_state_e;
endpackage

// File: rtl/burst_arbiter.sv
module burst_arbiter #(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle,
  input  logic [LVL_W-1:0] cur_len,
  input  logic             rx_en,
  input  logic             rx_dma_req,
  input  logic [LVL_W-1:0] rx_fifo_level,
  input  logic             tx_en,
  input  logic             tx_dma_req,
  input  logic [LVL_W-1:0] tx_fifo_free,
  output logic             grant_rx,
  output logic             grant_tx
);
  logic rx_ok, tx_ok, prefer_tx_q;

  always_comb begin
    rx_ok    = rx_en && rx_dma_req && (rx_fifo_level >= cur_len);
    tx_ok    = tx_en && tx_dma_req && (tx_fifo_free >= cur_len);
    grant_rx = idle && rx_ok && (!tx_ok || !prefer_tx_q);
    grant_tx = idle && tx_ok && (!rx_ok || prefer_tx_q);
  end

  // Priority flips toward the direction that was not served last.
  always_ff @(posedge clk) begin
    if (rst)           prefer_tx_q <= 1'b0;
    else if (grant_rx) prefer_tx_q <= 1'b1;
    else if (grant_tx) prefer_tx_q <= 1'b0;
  end
endmodule

// File: rtl/burst_len_counter.sv
module burst_len_counter #(
  parameter int LVL_W    = 12,
  parameter int BURST_SS = 512,
  parameter int BURST_HS = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_ss,
  input  logic             load,
  input  logic             dec,
  output logic [LVL_W-1:0] cur_len,
  output logic             last
);
  localparam int MAX_LEN = (BURST_SS > BURST_HS) ? BURST_SS : BURST_HS;
  localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign cur_len = mode_ss ? LVL_W'(BURST_SS) : LVL_W'(BURST_HS);
  assign last    = (cnt_q == '0);

  // Speed mode is captured only on load; it is ignored for the rest of a burst.
  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= mode_ss ? CNT_W'(BURST_SS - 1) : CNT_W'(BURST_HS - 1);
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_rd,
  input  logic [DATA_W-1:0] rx_fifo_data,
  input  logic              tx_accept,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_valid,
  output logic              tx_fifo_wr,
  output logic [DATA_W-1:0] tx_fifo_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_dout_valid <= 1'b0;
      tx_fifo_wr     <= 1'b0;
    end else begin
      bus_dout_valid <= rx_rd;
      tx_fifo_wr     <= tx_accept;
    end
  end

  // Data registers carry no reset so they map onto plain fabric flops.
  always_ff @(posedge clk) begin
    if (rx_rd)     bus_dout     <= rx_fifo_data;
    if (tx_accept) tx_fifo_data <= bus_din;
  end
endmodule

// File: rtl/burst_dma_ctrl.sv
module burst_dma_ctrl
  import burst_dma_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LVL_W    = 12,
  parameter int BURST_SS = 512,
  parameter int BURST_HS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_ss,
  input  logic              rx_en,
  input  logic              rx_dma_req,
  input  logic [LVL_W-1:0]  rx_fifo_level,
  input  logic [DATA_W-1:0] rx_fifo_data,
  output logic              rx_fifo_rd,
  input  logic              tx_en,
  input  logic              tx_dma_req,
  input  logic [LVL_W-1:0]  tx_fifo_free,
  output logic              tx_fifo_wr,
  output logic [DATA_W-1:0] tx_fifo_data,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_din_valid,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_valid,
  output logic              bus_dir
);
  dma_state_e       state_q, state_d;
  logic             grant_rx, grant_tx, last, tx_accept;
  logic [LVL_W-1:0] cur_len;

  burst_arbiter #(.LVL_W(LVL_W)) u_arb (
    .clk(clk), .rst(rst), .idle(state_q == ST_IDLE), .cur_len(cur_len),
    .rx_en(rx_en), .rx_dma_req(rx_dma_req), .rx_fifo_level(rx_fifo_level),
    .tx_en(tx_en), .tx_dma_req(tx_dma_req), .tx_fifo_free(tx_fifo_free),
    .grant_rx(grant_rx), .grant_tx(grant_tx)
  );

  burst_len_counter #(.LVL_W(LVL_W), .BURST_SS(BURST_SS), .BURST_HS(BURST_HS)) u_cnt (
    .clk(clk), .rst(rst), .mode_ss(mode_ss),
    .load(grant_rx || grant_tx),
    .dec((state_q == ST_RX) || tx_accept),
    .cur_len(cur_len), .last(last)
  );

  assign rx_fifo_rd = (state_q == ST_RX);
  assign bus_dir    = (state_q == ST_TX);
  assign tx_accept  = bus_dir && bus_din_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (grant_rx) state_d = ST_RX;
               else if (grant_tx) state_d = ST_TX;
      ST_RX:   if (last) state_d = ST_TURN;
      ST_TX:   if (tx_accept && last) state_d = ST_TURN;
      ST_TURN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  burst_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .rx_rd(rx_fifo_rd), .rx_fifo_data(rx_fifo_data),
    .tx_accept(tx_accept), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_dout_valid(bus_dout_valid),
    .tx_fifo_wr(tx_fifo_wr), .tx_fifo_data(tx_fifo_data)
  );
endmodule

// File: rtl/burst_dma_checker.sv
module burst_dma_checker #(
  parameter int LVL_W    = 12,
  parameter int BURST_SS = 512,
  parameter int BURST_HS = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_ss,
  input logic             rx_en,
  input logic             rx_dma_req,
  input logic [LVL_W-1:0] rx_fifo_level,
  input logic             tx_en,
  input logic             tx_dma_req,
  input logic [LVL_W-1:0] tx_fifo_free,
  input logic             rx_fifo_rd,
  input logic             bus_dir,
  input logic             bus_din_valid,
  input logic             tx_fifo_wr,
  input logic             bus_dout_valid
);
  localparam logic [LVL_W-1:0] LEN_SS = LVL_W'(BURST_SS);
  localparam logic [LVL_W-1:0] LEN_HS = LVL_W'(BURST_HS);

  logic             rd_q, dir_q, mode_q, rx_ok_q, tx_ok_q;
  logic [LVL_W-1:0] run_q, len_lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0; dir_q <= 1'b0; mode_q <= 1'b0;
      rx_ok_q <= 1'b0; tx_ok_q <= 1'b0;
      run_q <= '0; len_lat_q <= LEN_HS;
    end else begin
      rd_q    <= rx_fifo_rd;
      dir_q   <= bus_dir;
      mode_q  <= mode_ss;
      rx_ok_q <= rx_en && rx_dma_req && (rx_fifo_level >= (mode_ss ? LEN_SS : LEN_HS));
      tx_ok_q <= tx_en && tx_dma_req && (tx_fifo_free >= (mode_ss ? LEN_SS : LEN_HS));
      run_q   <= rx_fifo_rd ? run_q + 1'b1 : '0;
      if (rx_fifo_rd && !rd_q) len_lat_q <= mode_q ? LEN_SS : LEN_HS;
    end
  end

  AST_RX_START_GUARD: assert property (@(posedge clk) disable iff (rst)
    (rx_fifo_rd && !rd_q) |-> rx_ok_q); // R2
  AST_TX_START_GUARD: assert property (@(posedge clk) disable iff (rst)
    (bus_dir && !dir_q) |-> tx_ok_q); // R3
  AST_RX_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (!rx_fifo_rd && rd_q) |-> (run_q == len_lat_q)); // R4
  AST_RX_NO_EARLY_END: assert property (@(posedge clk) disable iff (rst)
    (!rx_fifo_rd && rd_q) |-> (run_q >= LEN_HS)); // R5
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rx_fifo_rd |=> bus_dout_valid); // R6
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    !rx_fifo_rd |=> !bus_dout_valid); // R6
  AST_WR_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (rst)
    (bus_dir && bus_din_valid) |=> tx_fifo_wr); // R7
  AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (rst)
    !(bus_dir && bus_din_valid) |=> !tx_fifo_wr); // R7
  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (rst)
    (rd_q && !rx_fifo_rd) |=> (!rx_fifo_rd && !bus_dir)); // R8
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rx_fifo_rd && bus_dir)); // R10
  AST_WR_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rx_fifo_rd && tx_fifo_wr)); // R10
endmodule

bind burst_dma_ctrl burst_dma_checker #(
  .LVL_W(LVL_W), .BURST_SS(BURST_SS), .BURST_HS(BURST_HS)
) u_chk (.*);

// File: tb/tb_burst_dma_ctrl.sv
module tb_burst_dma_ctrl;
  localparam int DATA_W = 16;
  localparam int LVL_W  = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic mode_ss = 0, rx_en = 0, rx_dma_req = 0, tx_en = 0, tx_dma_req = 0;
  logic [LVL_W-1:0] rx_fifo_level = '0, tx_fifo_free = '0;
  logic [DATA_W-1:0] rx_fifo_data, bus_din, tx_fifo_data, bus_dout;
  logic bus_din_valid = 0, rx_fifo_rd, tx_fifo_wr, bus_dout_valid, bus_dir;

  logic [DATA_W-1:0] rx_word = 16'h1000, tx_word = 16'h8000;
  bit   gappy = 0;
  int   n_chk = 0, n_bad = 0, cyc = 0;

  burst_dma_ctrl #(.DATA_W(DATA_W), .LVL_W(LVL_W)) dut (.*);

  always #10 clk = ~clk;

  assign rx_fifo_data = rx_word;
  assign bus_din      = tx_word;

  // FIFO and bridge models: advance on each consumed word.
  always @(posedge clk) begin
    if (rx_fifo_rd) rx_word <= rx_word + 16'd3;
    if (bus_dir && bus_din_valid) tx_word <= tx_word + 16'd5;
  end
  always @(posedge clk) begin
    #1 bus_din_valid = gappy ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Per-cycle monitor of pipelines and exclusivity.
  bit prev_rd = 0, prev_acc = 0;
  logic [DATA_W-1:0] prev_rdat = '0, prev_tdat = '0;
  always @(negedge clk) begin
    if (rst) begin
      prev_rd = 0; prev_acc = 0;
    end else begin
      chk(!(rx_fifo_rd && bus_dir), "R10 rd/dir overlap", int'(rx_fifo_rd && bus_dir), 0);
      if (prev_rd) chk(bus_dout_valid && bus_dout == prev_rdat, "R6 rx word", int'(bus_dout), int'(prev_rdat));
      else         chk(!bus_dout_valid, "R6 stray valid", int'(bus_dout_valid), 0);
      if (prev_acc) chk(tx_fifo_wr && tx_fifo_data == prev_tdat, "R7 tx word", int'(tx_fifo_data), int'(prev_tdat));
      else          chk(!tx_fifo_wr, "R7 stray write", int'(tx_fifo_wr), 0);
      prev_rd = rx_fifo_rd;   prev_rdat = rx_fifo_data;
      prev_acc = bus_dir && bus_din_valid; prev_tdat = bus_din;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected < %0d", cyc, 60000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // kind: 1 = RX, 2 = TX, 0 = none seen; low = quiet cycles before start incl. the one consumed earlier
  task automatic wait_burst(output int kind, output int cycles, output int words, output int low);
    kind = 0; cycles = 0; words = 0; low = 1;
    forever begin
      @(negedge clk);
      if (rx_fifo_rd) begin kind = 1; break; end
      if (bus_dir)    begin kind = 2; break; end
      low++;
      if (low > 3000) begin chk(0, "burst timeout", 0, 1); return; end
    end
    while ((kind == 1 && rx_fifo_rd) || (kind == 2 && bus_dir)) begin
      cycles++;
      if (kind == 1 || bus_din_valid) words++;
      @(negedge clk);
    end
  endtask

  task automatic expect_quiet(int n, string req);
    bit seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (rx_fifo_rd || bus_dir) seen = 1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!rx_fifo_rd && !tx_fifo_wr && !bus_dout_valid && !bus_dir, "R1 outputs in reset",
        int'({rx_fifo_rd, tx_fifo_wr, bus_dout_valid, bus_dir}), 0);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk(!rx_fifo_rd && !tx_fifo_wr && !bus_dout_valid && !bus_dir, "R1 outputs after reset",
        int'({rx_fifo_rd, tx_fifo_wr, bus_dout_valid, bus_dir}), 0);
  endtask

  task automatic t_rx_gate();
    int k, c, w, l;
    #1 mode_ss = 0; rx_en = 1; rx_dma_req = 1; rx_fifo_level = 255;
    expect_quiet(8, "R2 level one short");
    #1 rx_fifo_level = 300; rx_en = 0;
    expect_quiet(8, "R2 rx disabled");
    #1 rx_en = 1; rx_dma_req = 0;
    expect_quiet(8, "R2 no dma request");
    #1 rx_dma_req = 1; rx_fifo_level = 256;
    fork
      wait_burst(k, c, w, l);
      begin
        repeat (12) @(posedge clk);
        #1 rx_en = 0; rx_dma_req = 0; rx_fifo_level = 0;
      end
    join
    chk(k == 1, "R2 rx burst granted", k, 1);
    chk(c == 256, "R5 rx length kept after withdrawal", c, 256);
    expect_quiet(6, "R2 no start after withdrawal");
  endtask

  task automatic t_rx_mode();
    int k, c, w, l;
    #1 mode_ss = 1; rx_en = 1; rx_dma_req = 1; rx_fifo_level = 600;
    fork
      wait_burst(k, c, w, l);
      begin
        repeat (20) @(posedge clk);
        #1 mode_ss = 0;
      end
    join
    chk(k == 1 && c == 512, "R4 superspeed length held", c, 512);
    wait_burst(k, c, w, l);
    chk(l == 2, "R8 turnaround gap", l, 2);
    chk(k == 1 && c == 256, "R4 high-speed length", c, 256);
    #1 rx_en = 0;
    @(negedge clk);
  endtask

  task automatic t_tx();
    int k, c, w, l;
    #1 mode_ss = 0; tx_en = 1; tx_dma_req = 1; tx_fifo_free = 255;
    expect_quiet(8, "R3 free one short");
    #1 tx_fifo_free = 1000; tx_en = 0;
    expect_quiet(8, "R3 tx disabled");
    #1 tx_en = 1; tx_dma_req = 0;
    expect_quiet(8, "R3 no dma request");
    gappy = 1;
    #1 tx_dma_req = 1;
    wait_burst(k, c, w, l);
    chk(k == 2, "R3 tx burst granted", k, 2);
    chk(w == 256, "R7 tx words accepted", w, 256);
    chk(c > 256, "R7 idle bus cycles not counted", c, 257);
    #1 tx_en = 0; gappy = 0;
    @(negedge clk);
  endtask

  task automatic t_prio();
    int k, c, w, l;
    #1 rx_en = 0; tx_en = 0;
    do_reset();
    #1 mode_ss = 0; rx_en = 1; rx_dma_req = 1; rx_fifo_level = 400;
    tx_en = 1; tx_dma_req = 1; tx_fifo_free = 400;
    wait_burst(k, c, w, l);
    chk(k == 1, "R9 rx first after reset", k, 1);
    wait_burst(k, c, w, l);
    chk(k == 2 && l == 2, "R9 tx second", k, 2);
    wait_burst(k, c, w, l);
    chk(k == 1, "R9 rx third", k, 1);
    #1 rx_en = 0; tx_en = 0;
    expect_quiet(4, "R9 quiet after disable");
  endtask

  initial begin
    do_reset();
    t_rx_gate();
    t_rx_mode();
    t_tx();
    t_prio();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule